// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a logical address, a segment number plus an offset, into a physical address. It reads a descriptor for the segment from a table held in memory. Two configuration registers describe the table: a table origin and a table length, which is the number of legal segments. Each descriptor gives the segment's starting physical address and its length, a validation bit, and read, write and execute permission bits. The unit checks the segment number against the table length before it reads memory. It then checks the validation bit, the offset against the segment length and the access type against the permissions. It returns either the physical address or a fault with a cause code.

A request is a one-cycle strobe with the segment, the offset and the access type. Table reads go out on a simple request/return port. The address is word-granular: one descriptor per word, with the word address equal to table origin plus segment number. The most recently fetched descriptor is kept in a one-entry store. A repeat access to the same segment is then answered without a memory read. Any configuration write empties that store.

Top module: `seg_xlate`

## Requirements
- R1: After reset, done_o, fault_o, busy_o and mem_req_o are 0, cause_o is 0 and paddr_o is 0.
- R2: An accepted request whose segment number is not less than the length register completes one cycle after the start with fault_o=1 and cause_o=1. No table read is issued for it.
- R3: For a segment in range that is not held locally, one table read is issued at word address origin+segment. The descriptor word has base in bits [AW-1:0], limit in bits [AW+OW-1:AW], read at bit AW+OW, write at AW+OW+1, execute at AW+OW+2 and valid at AW+OW+3. On success paddr_o = (base + offset) mod 2^AW, with fault_o=0 and cause_o=0, and done_o rises one cycle after the read data is accepted.
- R4: A descriptor with valid=0 faults with cause_o=2, whatever its limit and permissions are.
- R5: A valid descriptor whose limit is not greater than the offset faults with cause_o=3, whatever the permissions are.
- R6: Access types are encoded 0=read, 1=write, 2=execute and 3=reserved. An in-limit access whose matching permission bit is 0 faults with cause_o=4. Type 3 always faults with cause_o=4.
- R7: A request for the same segment as the last fetched descriptor issues no table read, provided no configuration write has taken place since that fetch. It completes one cycle after the start.
- R8: A configuration write (cfg_sel_i 0 = origin, 1 = length) empties the local descriptor store. If the write falls in the same cycle as a table read return, the store stays empty, but that read's result is still delivered.
- R9: A start strobe while busy_o=1 is ignored. It produces no extra completion and does not change the translation in flight.
- R10: done_o is a one-cycle pulse. On a fault paddr_o is 0. fault_o, cause_o and paddr_o hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Configuration register write strobe |
| cfg_sel_i | input | 1 | 0 = table origin, 1 = table length |
| cfg_data_i | input | AW | Configuration write data (length uses the low SW+1 bits) |
| req_valid_i | input | 1 | Translation start strobe |
| req_seg_i | input | SW | Segment number |
| req_off_i | input | OW | Offset within the segment |
| req_acc_i | input | 2 | Access type |
| mem_req_o | output | 1 | Table read request, held until return |
| mem_addr_o | output | AW | Table word address |
| mem_rvalid_i | input | 1 | Table read data valid |
| mem_rdata_i | input | AW+OW+4 | Descriptor word |
| busy_o | output | 1 | Translation in flight |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 1 | Completion was a fault |
| cause_o | output | 3 | Fault cause (0 none, 1 range, 2 invalid, 3 limit, 4 permission) |
| paddr_o | output | AW | Physical address |

## Verification
Two functions can fall in the same cycle: the return of a table read, which would fill the local descriptor store, and a configuration write, which empties it. The bench provokes the collision with its memory model. In the very cycle that model returns the descriptor, it also writes the length register again with an unchanged value. The case is judged on two points. The translation result must be correct. A repeat access to that segment must then issue a fresh table read, which a bench counter of served reads shows.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_RANGE   = 3'd1,
    CAUSE_INVALID = 3'd2,
    CAUSE_LIMIT   = 3'd3,
    CAUSE_PERM    = 3'd4
  } cause_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } st_e;
endpackage

// File: rtl/seg_cfg_regs.sv
module seg_cfg_regs #(
  parameter int AW = 16,
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          sel_i,
  input  logic [AW-1:0] data_i,
  output logic [AW-1:0] origin_o,
  output logic [SW:0]   len_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      origin_o <= '0;
      len_o    <= '0;
    end else if (wr_i) begin
      if (sel_i) len_o    <= data_i[SW:0];
      else       origin_o <= data_i;
    end
  end
endmodule

// File: rtl/seg_entry_cache.sv
module seg_entry_cache #(
  parameter int SW = 4,
  parameter int EW = 28
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          fill_i,
  input  logic [SW-1:0] fill_seg_i,
  input  logic [EW-1:0] fill_entry_i,
  input  logic [SW-1:0] look_seg_i,
  output logic          hit_o,
  output logic [EW-1:0] entry_o
);
  logic          vld_q;
  logic [SW-1:0] seg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      seg_q   <= '0;
      entry_o <= '0;
    end else if (clear_i) begin
      vld_q <= 1'b0;
    end else if (fill_i) begin
      vld_q   <= 1'b1;
      seg_q   <= fill_seg_i;
      entry_o <= fill_entry_i;
    end
  end

  assign hit_o = vld_q && (seg_q == look_seg_i);
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int AW = 16,
  parameter int OW = 8,
  parameter int EW = AW + OW + 4
) (
  input  logic [EW-1:0] entry_i,
  input  logic [OW-1:0] off_i,
  input  logic [1:0]    acc_i,
  output cause_e        cause_o,
  output logic [AW-1:0] paddr_o
);
  localparam int PB = AW + OW;

  logic [AW-1:0] base;
  logic [OW-1:0] limit;
  logic [2:0]    perm;
  logic          valid;
  logic          allowed;

  assign base  = entry_i[AW-1:0];
  assign limit = entry_i[AW+:OW];
  assign perm  = entry_i[PB+:3];
  assign valid = entry_i[PB+3];

  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_READ:  allowed = perm[0];
      ACC_WRITE: allowed = perm[1];
      ACC_EXEC:  allowed = perm[2];
      default:   allowed = 1'b0;
    endcase
  end

  always_comb begin
    if (!valid)              cause_o = CAUSE_INVALID;
    else if (off_i >= limit) cause_o = CAUSE_LIMIT;
    else if (!allowed)       cause_o = CAUSE_PERM;
    else                     cause_o = CAUSE_NONE;
  end

  assign paddr_o = base + AW'(off_i);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int AW = 16,
  parameter int SW = 4,
  parameter int OW = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_wr_i,
  input  logic               cfg_sel_i,
  input  logic [AW-1:0]      cfg_data_i,
  input  logic               req_valid_i,
  input  logic [SW-1:0]      req_seg_i,
  input  logic [OW-1:0]      req_off_i,
  input  logic [1:0]         req_acc_i,
  output logic               mem_req_o,
  output logic [AW-1:0]      mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [AW+OW+3:0]   mem_rdata_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               fault_o,
  output logic [2:0]         cause_o,
  output logic [AW-1:0]      paddr_o
);
  localparam int EW = AW + OW + 4;

  st_e           state_q;
  logic [SW-1:0] seg_q;
  logic [OW-1:0] off_q;
  logic [1:0]    acc_q;
  logic [AW-1:0] addr_q;

  logic [AW-1:0] cfg_origin;
  logic [SW:0]   cfg_len;
  logic          hit_raw;
  logic [EW-1:0] cache_entry;
  logic          accept, in_range, hit, fill;
  logic [EW-1:0] chk_entry;
  logic [OW-1:0] chk_off;
  logic [1:0]    chk_acc;
  cause_e        chk_cause;
  logic [AW-1:0] chk_paddr;

  seg_cfg_regs #(.AW(AW), .SW(SW)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cfg_wr_i),
    .sel_i    (cfg_sel_i),
    .data_i   (cfg_data_i),
    .origin_o (cfg_origin),
    .len_o    (cfg_len)
  );

  // a config write in the fill cycle wins: the store stays empty
  assign fill = (state_q == ST_FETCH) && mem_rvalid_i && !cfg_wr_i;

  seg_entry_cache #(.SW(SW), .EW(EW)) u_cache (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (cfg_wr_i),
    .fill_i       (fill),
    .fill_seg_i   (seg_q),
    .fill_entry_i (mem_rdata_i),
    .look_seg_i   (req_seg_i),
    .hit_o        (hit_raw),
    .entry_o      (cache_entry)
  );

  assign accept   = (state_q == ST_IDLE) && req_valid_i;
  assign in_range = {1'b0, req_seg_i} < cfg_len;
  assign hit      = hit_raw && !cfg_wr_i;

  always_comb begin
    if (state_q == ST_FETCH) begin
      chk_entry = mem_rdata_i;
      chk_off   = off_q;
      chk_acc   = acc_q;
    end else begin
      chk_entry = cache_entry;
      chk_off   = req_off_i;
      chk_acc   = req_acc_i;
    end
  end

  seg_check #(.AW(AW), .OW(OW), .EW(EW)) u_check (
    .entry_i (chk_entry),
    .off_i   (chk_off),
    .acc_i   (chk_acc),
    .cause_o (chk_cause),
    .paddr_o (chk_paddr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      seg_q   <= '0;
      off_q   <= '0;
      acc_q   <= '0;
      addr_q  <= '0;
      done_o  <= 1'b0;
      fault_o <= 1'b0;
      cause_o <= '0;
      paddr_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (!in_range) begin
              done_o  <= 1'b1;
              fault_o <= 1'b1;
              cause_o <= CAUSE_RANGE;
              paddr_o <= '0;
            end else if (hit) begin
              done_o  <= 1'b1;
              fault_o <= (chk_cause != CAUSE_NONE);
              cause_o <= chk_cause;
              paddr_o <= (chk_cause == CAUSE_NONE) ? chk_paddr : '0;
            end else begin
              state_q <= ST_FETCH;
              seg_q   <= req_seg_i;
              off_q   <= req_off_i;
              acc_q   <= req_acc_i;
              addr_q  <= cfg_origin + AW'(req_seg_i);
            end
          end
        end
        ST_FETCH: begin
          if (mem_rvalid_i) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
            fault_o <= (chk_cause != CAUSE_NONE);
            cause_o <= chk_cause;
            paddr_o <= (chk_cause == CAUSE_NONE) ? chk_paddr : '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (state_q == ST_FETCH);
  assign mem_addr_o = addr_q;
  assign busy_o     = (state_q != ST_IDLE);
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int AW = 16,
  parameter int SW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_wr_i,
  input logic          req_valid_i,
  input logic [SW-1:0] req_seg_i,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rvalid_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          fault_o,
  input logic [2:0]    cause_o,
  input logic [AW-1:0] paddr_o,
  input logic [SW:0]   cfg_len_i,
  input logic          hit_raw_i
);
  p_range_no_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && ({1'b0, req_seg_i} >= cfg_len_i))
    |=> (done_o && fault_o && cause_o == 3'd1 && !mem_req_o));

  p_read_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_clear_on_cfg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i |=> !hit_raw_i);

  p_busy_ignores_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_rvalid_i) |=> !done_o);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_fault_paddr_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (paddr_o == '0 && cause_o != 3'd0));

  p_ok_cause_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |-> (cause_o == 3'd0));

  p_hold_result_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(fault_o) && $stable(cause_o) && $stable(paddr_o)));
endmodule

bind seg_xlate seg_xlate_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_wr_i     (cfg_wr_i),
  .req_valid_i  (req_valid_i),
  .req_seg_i    (req_seg_i),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .fault_o      (fault_o),
  .cause_o      (cause_o),
  .paddr_o      (paddr_o),
  .cfg_len_i    (cfg_len),
  .hit_raw_i    (hit_raw)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int SW = 4;
  localparam int OW = 8;
  localparam int EW = AW + OW + 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_wr_i, cfg_sel_i;
  logic [AW-1:0] cfg_data_i;
  logic          req_valid_i = 1'b0;
  logic [SW-1:0] req_seg_i = '0;
  logic [OW-1:0] req_off_i = '0;
  logic [1:0]    req_acc_i = '0;
  logic          mem_req_o;
  logic [AW-1:0] mem_addr_o;
  logic          mem_rvalid_i = 1'b0;
  logic [EW-1:0] mem_rdata_i = '0;
  logic          busy_o, done_o, fault_o;
  logic [2:0]    cause_o;
  logic [AW-1:0] paddr_o;

  logic          t_wr = 1'b0, t_sel = 1'b0;
  logic [AW-1:0] t_data = '0;
  logic          ret_wr = 1'b0;
  logic          wr_on_return = 1'b0;
  logic [AW-1:0] len_val = 16'd6;

  assign cfg_wr_i   = t_wr | ret_wr;
  assign cfg_sel_i  = ret_wr ? 1'b1 : t_sel;
  assign cfg_data_i = ret_wr ? len_val : t_data;

  logic [EW-1:0] tbl [0:63];
  int reads = 0;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  seg_xlate #(.AW(AW), .SW(SW), .OW(OW)) u_dut (
    .clk_i, .rst_ni, .cfg_wr_i, .cfg_sel_i, .cfg_data_i,
    .req_valid_i, .req_seg_i, .req_off_i, .req_acc_i,
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .busy_o, .done_o, .fault_o, .cause_o, .paddr_o
  );

  // memory: answers one cycle after the request is seen
  always @(negedge clk_i) begin
    ret_wr <= 1'b0;
    if (mem_req_o && !mem_rvalid_i) begin
      mem_rvalid_i <= 1'b1;
      mem_rdata_i  <= tbl[mem_addr_o[5:0]];
      reads        <= reads + 1;
      if (wr_on_return) ret_wr <= 1'b1;
    end else begin
      mem_rvalid_i <= 1'b0;
    end
  end

  function automatic logic [EW-1:0] mk(input logic v, input logic x, input logic w,
                                       input logic r, input logic [OW-1:0] lim,
                                       input logic [AW-1:0] base);
    return {v, x, w, r, lim, base};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [AW-1:0] d);
    @(negedge clk_i);
    t_wr = 1'b1; t_sel = sel; t_data = d;
    @(negedge clk_i);
    t_wr = 1'b0;
  endtask

  task automatic xlate(input logic [SW-1:0] seg, input logic [OW-1:0] off,
                       input logic [1:0] acc, output int cyc, output int nrd);
    int r0;
    @(negedge clk_i);
    r0 = reads;
    req_valid_i = 1'b1; req_seg_i = seg; req_off_i = off; req_acc_i = acc;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 50) begin
      @(negedge clk_i);
      cyc++;
    end
    nrd = reads - r0;
  endtask

  task automatic expect_res(input string tag, input logic [SW-1:0] seg,
                            input logic [OW-1:0] off, input logic [1:0] acc,
                            input logic [2:0] ecause, input logic [AW-1:0] epa,
                            input int ecyc, input int erd);
    int cyc, nrd;
    xlate(seg, off, acc, cyc, nrd);
    chk(done_o == 1'b1, {tag, " done"}, done_o, 1);
    chk(cause_o == ecause, {tag, " cause"}, cause_o, ecause);
    chk(fault_o == (ecause != 0), {tag, " fault"}, fault_o, ecause != 0);
    chk(paddr_o == epa, {tag, " paddr"}, paddr_o, epa);
    chk(cyc == ecyc, {tag, " latency"}, cyc, ecyc);
    chk(nrd == erd, {tag, " reads"}, nrd, erd);
    @(negedge clk_i);
    chk(done_o == 1'b0, {tag, " R10 pulse"}, done_o, 0);
  endtask

  task automatic t_reset;
    chk(!done_o && !fault_o && !busy_o && !mem_req_o, "R1 flags", {done_o, fault_o, busy_o, mem_req_o}, 0);
    chk(cause_o == 0 && paddr_o == 0, "R1 values", {cause_o, paddr_o}, 0);
  endtask

  task automatic t_range;
    expect_res("R2 seg=len", 4'd6, 8'h00, 2'd0, 3'd1, 16'h0, 1, 0);
    expect_res("R2 seg=15", 4'd15, 8'h01, 2'd2, 3'd1, 16'h0, 1, 0);
  endtask

  task automatic t_success;
    expect_res("R3 read ok", 4'd0, 8'h10, 2'd0, 3'd0, 16'h1010, 2, 1);
    expect_res("R3 wrap", 4'd3, 8'h20, 2'd1, 3'd0, 16'h0010, 2, 1);
  endtask

  task automatic t_hit;
    expect_res("R7 repeat", 4'd3, 8'h05, 2'd2, 3'd0, 16'hfff5, 1, 0);
  endtask

  task automatic t_faults;
    expect_res("R4 invalid", 4'd1, 8'h00, 2'd0, 3'd2, 16'h0, 2, 1);
    expect_res("R5 at limit", 4'd2, 8'h20, 2'd1, 3'd3, 16'h0, 2, 1);
    expect_res("R6 write denied", 4'd2, 8'h1f, 2'd1, 3'd4, 16'h0, 1, 0);
    expect_res("R5 R6 read last byte", 4'd2, 8'h1f, 2'd0, 3'd0, 16'h221f, 1, 0);
    expect_res("R6 reserved type", 4'd2, 8'h00, 2'd3, 3'd4, 16'h0, 1, 0);
    expect_res("R6 exec ok", 4'd4, 8'h07, 2'd2, 3'd0, 16'h4007, 2, 1);
    expect_res("R6 read on exec-only", 4'd4, 8'h07, 2'd0, 3'd4, 16'h0, 1, 0);
  endtask

  task automatic t_cfg_clear;
    cfg_write(1'b1, len_val);
    expect_res("R8 refetch after len write", 4'd4, 8'h01, 2'd2, 3'd0, 16'h4001, 2, 1);
    cfg_write(1'b0, 16'd32);
    expect_res("R8 R3 new origin", 4'd0, 8'h02, 2'd0, 3'd0, 16'h7702, 2, 1);
    cfg_write(1'b0, 16'd8);
  endtask

  task automatic t_collide;
    wr_on_return = 1'b1;
    expect_res("R8 collide result", 4'd5, 8'h03, 2'd0, 3'd0, 16'h5003, 2, 1);
    wr_on_return = 1'b0;
    expect_res("R8 collide store empty", 4'd5, 8'h04, 2'd0, 3'd0, 16'h5004, 2, 1);
    expect_res("R8 refilled", 4'd5, 8'h04, 2'd0, 3'd0, 16'h5004, 1, 0);
  endtask

  task automatic t_busy;
    int cyc;
    cfg_write(1'b1, len_val);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_seg_i = 4'd0; req_off_i = 8'h11; req_acc_i = 2'd0;
    @(negedge clk_i);
    req_seg_i = 4'd15;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(done_o && cause_o == 0 && paddr_o == 16'h1011, "R9 in-flight kept", paddr_o, 16'h1011);
    cyc = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      if (done_o) cyc++;
    end
    chk(cyc == 0, "R9 no extra completion", cyc, 0);
    chk(cause_o == 0 && paddr_o == 16'h1011, "R10 hold", paddr_o, 16'h1011);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) tbl[i] = '0;
    tbl[8]  = mk(1, 0, 0, 1, 8'h40, 16'h1000);
    tbl[9]  = mk(0, 1, 1, 1, 8'hff, 16'h9000);
    tbl[10] = mk(1, 0, 0, 1, 8'h20, 16'h2200);
    tbl[11] = mk(1, 1, 1, 1, 8'h80, 16'hfff0);
    tbl[12] = mk(1, 1, 0, 0, 8'h10, 16'h4000);
    tbl[13] = mk(1, 0, 0, 1, 8'h10, 16'h5000);
    tbl[32] = mk(1, 0, 0, 1, 8'h10, 16'h7700);
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    cfg_write(1'b0, 16'd8);
    cfg_write(1'b1, len_val);
    t_range();
    t_success();
    t_hit();
    t_faults();
    t_cfg_clear();
    t_collide();
    t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule